// File: doc/BRIEF.md
# Raster Line and Frame Timer with Vertical-Blank Interrupt

This block is the timing core of a tile-based video processor. It counts pixel-clock dots across each scanline and scanlines across each frame. It keeps the vertical-blank status flag and the two sprite status flags. It also drives a level interrupt request toward the host processor. Pixel generation and memory fetches are handled by other blocks that read its dot and line counts.

The host reaches the block through two strobes. A status read returns the flag byte and has side effects. A control write updates the interrupt enable. Both strobes capture their data at the access clock, but their side effects take hold one pixel clock later. Short race windows around the start of vertical blank follow from that delay and are part of the behaviour.

On every second frame, while rendering is enabled, the last dot of the pre-render line is dropped. Two consecutive frames therefore differ in length by one dot.

Top module: `raster_sync`

## Requirements
- R1: `dot_cnt` starts at 0, advances by one each clock up to 340, and then returns to 0 while `line_cnt` advances by one.
- R2: `line_cnt` runs from 0 to 261. At the end of line 261 both counters return to 0, and `frame_pulse` is high for exactly the one clock in which the counters show line 0, dot 0.
- R3: An internal frame parity bit starts at 0 and inverts at the clock where line 261 shows dot 339. When it goes from 1 to 0 at that clock and `render_en` is high, the next clock shows line 0, dot 0 and dot 340 is skipped. With rendering on from reset, the first two frames last 89342 and 89341 clocks.
- R4: The vertical-blank flag (`stat_byte` bit 7) reads 1 from the clock after the one that shows line 241, dot 1.
- R5: `spr0_hit_in` and `spr_ovf_in` set the sticky flags in `stat_byte` bits 6 and 5 from the next clock on. The clock that shows line 261, dot 1 clears bits 7, 6 and 5, and this clear takes effect from the following clock.
- R6: `stat_byte` always shows {vblank, sprite-zero hit, sprite overflow, `bus_low[4:0]`}. The value presented during a read clock is the value returned.
- R7: A strobe sampled at clock edge k takes effect at edge k+1. A status read clears the vertical-blank flag at edge k+1 and makes `wtog_clr` high for the one clock that follows edge k+1.
- R8: During dots 1 to 4 of line 241, `nmi_req` follows vblank AND enable. If a read takes effect on the dot-1 edge of line 241, the flag never shows as set and `nmi_req` stays low.
- R9: An enable write 0→1 raises `nmi_req` while vblank is set and leaves it low while vblank is clear. A 1→0 write that takes effect in dots 1 to 4 of line 241 drops `nmi_req`. A 1→0 write at any other time leaves `nmi_req` unchanged.
- R10: A status read that takes effect on line 241 forces `nmi_req` low. A read that takes effect on any other line leaves `nmi_req` unchanged.
- R11: `nmi_req` is cleared together with the status flags at dot 1 of line 261.
- R12: While `rst_n` is low, the counters, the flags, the enable, the parity bit, `nmi_req`, `frame_pulse` and `wtog_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Background or sprite rendering enabled |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_nmi_en | input | 1 | Interrupt enable value carried by the write |
| stat_rd | input | 1 | Status register read strobe |
| spr0_hit_in | input | 1 | Sprite-zero hit event from the pixel pipeline |
| spr_ovf_in | input | 1 | Sprite overflow event from sprite evaluation |
| bus_low | input | 5 | Low bits last left on the internal register bus |
| dot_cnt | output | 9 | Current dot within the line |
| line_cnt | output | 9 | Current scanline |
| nmi_req | output | 1 | Level interrupt request |
| frame_pulse | output | 1 | One-clock pulse at the start of each frame |
| stat_byte | output | 8 | Status byte returned on a read |
| wtog_clr | output | 1 | Reset pulse for the address-write toggle |

## Verification
The hardest states to reach are the races on line 241. These are a read whose deferred effect lands on the exact edge that sets the flag, and an enable clear that lands inside the four-dot window. Both need a strobe placed one clock before the target dot, so the bench tracks the raster position in its own counters and steps clock by clock up to those dots. The skipped dot appears only on the second frame after reset. The bench therefore runs two full frames with rendering on, uses random strobes and bus values in the visible lines, and places the directed race cases in the blanking lines of the same two frames.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int RS_DOTS       = 341;
  localparam int RS_LINES      = 262;
  localparam int RS_VBL_LINE   = 241;
  localparam int RS_NMI_LAST   = 4;

  // access captured at the strobe edge, applied one edge later
  typedef struct packed {
    logic wr;
    logic en;
    logic rd;
  } acc_t;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int DOTS  = raster_pkg::RS_DOTS,
  parameter int LINES = raster_pkg::RS_LINES,
  parameter int DW    = $clog2(DOTS),
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          render_en,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          frame_pulse
);

  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [DW-1:0] DOT_PAR   = DW'(DOTS - 2);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  logic [DW-1:0] dot_q, dot_d;
  logic [LW-1:0] line_q, line_d;
  logic          odd_q, odd_d;
  logic          fp_q, fp_d;
  logic          last_line, parity_pt, skip, end_line;

  always_comb begin
    last_line = (line_q == LINE_LAST);
    parity_pt = last_line && (dot_q == DOT_PAR);
    skip      = parity_pt && odd_q && render_en;
    end_line  = (dot_q == DOT_LAST) || skip;
    dot_d     = end_line ? '0 : dot_q + DW'(1);
    line_d    = line_q;
    if (end_line)
      line_d = last_line ? '0 : line_q + LW'(1);
    odd_d     = parity_pt ? ~odd_q : odd_q;
    fp_d      = end_line && last_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
      odd_q  <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      dot_q  <= dot_d;
      line_q <= line_d;
      odd_q  <= odd_d;
      fp_q   <= fp_d;
    end
  end

  assign dot         = dot_q;
  assign line        = line_q;
  assign frame_pulse = fp_q;

endmodule

// File: rtl/raster_decode.sv
module raster_decode #(
  parameter int LINES    = raster_pkg::RS_LINES,
  parameter int VBL_LINE = raster_pkg::RS_VBL_LINE,
  parameter int NMI_LAST = raster_pkg::RS_NMI_LAST,
  parameter int DW       = 9,
  parameter int LW       = 9
) (
  input  logic [DW-1:0] dot,
  input  logic [LW-1:0] line,
  output logic          set_evt,
  output logic          clr_evt,
  output logic          nmi_win,
  output logic          on_vbl_line
);

  localparam logic [LW-1:0] L_VBL = LW'(VBL_LINE);
  localparam logic [LW-1:0] L_PRE = LW'(LINES - 1);
  localparam logic [DW-1:0] D_ONE = DW'(1);
  localparam logic [DW-1:0] D_WIN = DW'(NMI_LAST);

  always_comb begin
    on_vbl_line = (line == L_VBL);
    set_evt     = on_vbl_line && (dot == D_ONE);
    clr_evt     = (line == L_PRE) && (dot == D_ONE);
    nmi_win     = on_vbl_line && (dot >= D_ONE) && (dot <= D_WIN);
  end

endmodule

// File: rtl/vblank_ctrl.sv
module vblank_ctrl
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic nmi_win,
  input  logic on_vbl_line,
  input  logic ctrl_wr,
  input  logic ctrl_nmi_en,
  input  logic stat_rd,
  input  logic hit_in,
  input  logic ovf_in,
  output logic vbl,
  output logic hit,
  output logic ovf,
  output logic nmi,
  output logic wtog_clr
);

  acc_t pend_q, pend_d;
  logic vbl_q, vbl_d, hit_q, hit_d, ovf_q, ovf_d;
  logic en_q, en_d, nmi_q, nmi_d, tog_q, tog_d;

  always_comb begin
    pend_d.wr = ctrl_wr;
    pend_d.en = ctrl_nmi_en;
    pend_d.rd = stat_rd;
    vbl_d = vbl_q;
    hit_d = hit_q;
    ovf_d = ovf_q;
    en_d  = en_q;
    nmi_d = nmi_q;
    tog_d = 1'b0;

    // raster events
    if (set_evt) vbl_d = 1'b1;
    if (clr_evt) begin
      vbl_d = 1'b0;
      hit_d = 1'b0;
      ovf_d = 1'b0;
      nmi_d = 1'b0;
    end else begin
      hit_d = hit_q | hit_in;
      ovf_d = ovf_q | ovf_in;
    end
    if (nmi_win) nmi_d = vbl_d & en_q;

    // deferred access effects land after the raster step
    if (pend_q.wr) begin
      en_d = pend_q.en;
      if (!en_q && pend_q.en && vbl_d) nmi_d = 1'b1;
      if (!pend_q.en && nmi_win)       nmi_d = 1'b0;
    end
    if (pend_q.rd) begin
      vbl_d = 1'b0;
      tog_d = 1'b1;
      if (on_vbl_line) nmi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vbl_q  <= 1'b0;
      hit_q  <= 1'b0;
      ovf_q  <= 1'b0;
      en_q   <= 1'b0;
      nmi_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vbl_q  <= vbl_d;
      hit_q  <= hit_d;
      ovf_q  <= ovf_d;
      en_q   <= en_d;
      nmi_q  <= nmi_d;
      tog_q  <= tog_d;
    end
  end

  assign vbl      = vbl_q;
  assign hit      = hit_q;
  assign ovf      = ovf_q;
  assign nmi      = nmi_q;
  assign wtog_clr = tog_q;

endmodule

// File: rtl/raster_sync.sv
module raster_sync #(
  parameter int DOTS     = raster_pkg::RS_DOTS,
  parameter int LINES    = raster_pkg::RS_LINES,
  parameter int VBL_LINE = raster_pkg::RS_VBL_LINE,
  parameter int NMI_LAST = raster_pkg::RS_NMI_LAST,
  parameter int DW       = $clog2(DOTS),
  parameter int LW       = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          render_en,
  input  logic          ctrl_wr,
  input  logic          ctrl_nmi_en,
  input  logic          stat_rd,
  input  logic          spr0_hit_in,
  input  logic          spr_ovf_in,
  input  logic [4:0]    bus_low,
  output logic [DW-1:0] dot_cnt,
  output logic [LW-1:0] line_cnt,
  output logic          nmi_req,
  output logic          frame_pulse,
  output logic [7:0]    stat_byte,
  output logic          wtog_clr
);

  logic set_evt, clr_evt, nmi_win, on_vbl_line;
  logic vbl, hit, ovf;

  raster_counter #(.DOTS(DOTS), .LINES(LINES), .DW(DW), .LW(LW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .render_en   (render_en),
    .dot         (dot_cnt),
    .line        (line_cnt),
    .frame_pulse (frame_pulse)
  );

  raster_decode #(.LINES(LINES), .VBL_LINE(VBL_LINE), .NMI_LAST(NMI_LAST),
                  .DW(DW), .LW(LW)) u_dec (
    .dot         (dot_cnt),
    .line        (line_cnt),
    .set_evt     (set_evt),
    .clr_evt     (clr_evt),
    .nmi_win     (nmi_win),
    .on_vbl_line (on_vbl_line)
  );

  vblank_ctrl u_vbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_evt     (set_evt),
    .clr_evt     (clr_evt),
    .nmi_win     (nmi_win),
    .on_vbl_line (on_vbl_line),
    .ctrl_wr     (ctrl_wr),
    .ctrl_nmi_en (ctrl_nmi_en),
    .stat_rd     (stat_rd),
    .hit_in      (spr0_hit_in),
    .ovf_in      (spr_ovf_in),
    .vbl         (vbl),
    .hit         (hit),
    .ovf         (ovf),
    .nmi         (nmi_req),
    .wtog_clr    (wtog_clr)
  );

  assign stat_byte = {vbl, hit, ovf, bus_low};

endmodule

// File: rtl/raster_sync_chk.sv
module raster_sync_chk #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  parameter int DW       = 9,
  parameter int LW       = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stat_rd,
  input logic [DW-1:0] dot_cnt,
  input logic [LW-1:0] line_cnt,
  input logic          nmi_req,
  input logic          frame_pulse,
  input logic [7:0]    stat_byte,
  input logic          wtog_clr
);

  assert_dot_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dot_cnt == DW'(DOTS - 1) |=> dot_cnt == '0);

  assert_dot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dot_cnt <= DW'(DOTS - 1));

  assert_frame_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (dot_cnt == '0 && line_cnt == '0));

  assert_vbl_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt == LW'(VBL_LINE) && dot_cnt == DW'(1) && !$past(stat_rd))
      |=> stat_byte[7]);

  assert_preclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt == LW'(LINES - 1) && dot_cnt == DW'(1))
      |=> (stat_byte[7:5] == 3'b000 && !nmi_req));

  assert_nmi_needs_vbl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> stat_byte[7]);

  assert_toggle_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wtog_clr |-> $past(stat_rd, 2));

endmodule

bind raster_sync raster_sync_chk #(
  .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE), .DW(DW), .LW(LW)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_rd     (stat_rd),
  .dot_cnt     (dot_cnt),
  .line_cnt    (line_cnt),
  .nmi_req     (nmi_req),
  .frame_pulse (frame_pulse),
  .stat_byte   (stat_byte),
  .wtog_clr    (wtog_clr)
);

// File: tb/test_raster_sync.sv
module test_raster_sync;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       render_en, ctrl_wr, ctrl_nmi_en, stat_rd, hit_in, ovf_in;
  logic [4:0] bus_low;
  logic [8:0] dot_cnt, line_cnt;
  logic       nmi_req, frame_pulse, wtog_clr;
  logic [7:0] stat_byte;

  int n_checks = 0;
  int n_errors = 0;
  int m_dot = 0, m_line = 0;
  bit m_odd = 0, m_hit = 0, m_ovf = 0, exp_fp = 0, rd_p1 = 0, exp_tog = 0;
  int tick_cnt = 0, n_frames = 0;
  int lens [2];
  bit finished = 0;

  always #5 clk = ~clk;

  raster_sync i_raster_sync (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .ctrl_wr(ctrl_wr),
    .ctrl_nmi_en(ctrl_nmi_en), .stat_rd(stat_rd), .spr0_hit_in(hit_in),
    .spr_ovf_in(ovf_in), .bus_low(bus_low), .dot_cnt(dot_cnt),
    .line_cnt(line_cnt), .nmi_req(nmi_req), .frame_pulse(frame_pulse),
    .stat_byte(stat_byte), .wtog_clr(wtog_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d dot %0d)",
               req, act, exp, m_line, m_dot);
    end
  endtask

  // one clock: advance the bench raster model, then compare at the falling edge
  task automatic tick();
    int pl, pd;
    bit pp, sk, endl;
    @(posedge clk);
    pl = m_line; pd = m_dot;
    pp = (pl == 261) && (pd == 339);
    sk = pp && m_odd && render_en;
    if (pp) m_odd = ~m_odd;
    endl = (pd == 340) || sk;
    exp_fp = endl && (pl == 261);
    if (endl) begin
      m_dot = 0;
      m_line = (pl == 261) ? 0 : pl + 1;
    end else m_dot = pd + 1;
    if (pl == 261 && pd == 1) begin
      m_hit = 0; m_ovf = 0;
    end else begin
      if (hit_in) m_hit = 1;
      if (ovf_in) m_ovf = 1;
    end
    exp_tog = rd_p1;
    rd_p1 = stat_rd;
    @(negedge clk);
    tick_cnt++;
    chk("R1 dot", dot_cnt, m_dot);
    chk("R2 line", line_cnt, m_line);
    chk("R2 frame pulse", frame_pulse, exp_fp);
    chk("R5 sticky hit", stat_byte[6], m_hit);
    chk("R5 sticky ovf", stat_byte[5], m_ovf);
    chk("R6 low bits", stat_byte[4:0], bus_low);
    chk("R7 toggle clear", wtog_clr, exp_tog);
    if (frame_pulse && n_frames < 2) begin
      lens[n_frames] = tick_cnt;
      n_frames++;
      tick_cnt = 0;
    end
  endtask

  task automatic cyc();
    if (m_line < 240) begin
      bus_low     = 5'($urandom);
      ctrl_wr     = ($urandom % 64) == 0;
      ctrl_nmi_en = 1'($urandom);
      stat_rd     = !ctrl_wr && (($urandom % 50) == 0);
      hit_in      = ($urandom % 3000) == 0;
      ovf_in      = ($urandom % 3000) == 0;
    end
    tick();
    ctrl_wr = 0; stat_rd = 0; hit_in = 0; ovf_in = 0;
    if (m_line < 240) begin
      chk("R9 enable while vblank clear", nmi_req, 0);
      chk("R4 no vblank in visible lines", stat_byte[7], 0);
    end
  endtask

  task automatic goto(input int l, input int d);
    while (!(m_line == l && m_dot == d)) cyc();
  endtask

  task automatic pulse_wr(input bit en);
    ctrl_wr = 1; ctrl_nmi_en = en;
    tick();
    ctrl_wr = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1d2f);
    rst_n = 0; render_en = 1; ctrl_wr = 0; ctrl_nmi_en = 0; stat_rd = 0;
    hit_in = 0; ovf_in = 0; bus_low = 5'h0a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 dot", dot_cnt, 0);
    chk("R12 line", line_cnt, 0);
    chk("R12 nmi", nmi_req, 0);
    chk("R12 flags", stat_byte[7:5], 0);
    chk("R12 frame pulse", frame_pulse, 0);
    chk("R12 toggle clear", wtog_clr, 0);

    // ---- frame A: read races the vblank set ----
    goto(239, 5);
    hit_in = 1; ovf_in = 1;
    tick();
    hit_in = 0; ovf_in = 0;
    goto(240, 0);
    pulse_wr(1);
    goto(241, 0);
    stat_rd = 1;
    chk("R6 value read before set", stat_byte[7], 0);
    tick();
    stat_rd = 0;
    tick();
    chk("R8 race read hides vblank", stat_byte[7], 0);
    chk("R8 race read suppresses nmi", nmi_req, 0);
    goto(241, 10);
    chk("R8 nmi stays low after race", nmi_req, 0);
    goto(261, 1);
    chk("R5 flags set before clear", stat_byte[6:5], 3);
    tick();
    chk("R5 pre-render clear", stat_byte[7:5], 0);
    goto(0, 0);

    // ---- frame B: normal set, window disable, re-enable ----
    goto(239, 5);
    hit_in = 1;
    tick();
    hit_in = 0;
    goto(240, 0);
    pulse_wr(1);
    goto(241, 1);
    chk("R4 flag not yet set", stat_byte[7], 0);
    tick();
    chk("R4 vblank set", stat_byte[7], 1);
    chk("R8 nmi raised", nmi_req, 1);
    ctrl_wr = 1; ctrl_nmi_en = 0;
    tick();
    ctrl_wr = 0;
    chk("R7 write not yet applied", nmi_req, 1);
    tick();
    chk("R9 disable in window drops nmi", nmi_req, 0);
    chk("R9 vblank kept", stat_byte[7], 1);
    tick(); tick();
    chk("R8 nmi low with enable clear", nmi_req, 0);
    goto(245, 0);
    pulse_wr(1);
    chk("R7 enable deferred", nmi_req, 0);
    tick();
    chk("R9 enable while vblank set", nmi_req, 1);
    goto(250, 0);
    pulse_wr(0);
    tick();
    chk("R9 disable outside window", nmi_req, 1);
    goto(255, 0);
    stat_rd = 1;
    chk("R6 read returns vblank", stat_byte[7], 1);
    tick();
    stat_rd = 0;
    chk("R7 read clear deferred", stat_byte[7], 1);
    tick();
    chk("R7 read clears vblank", stat_byte[7], 0);
    chk("R10 read off line 241 keeps nmi", nmi_req, 1);
    goto(261, 1);
    chk("R11 nmi before pre-render", nmi_req, 1);
    tick();
    chk("R11 nmi cleared", nmi_req, 0);
    goto(0, 0);

    chk("R3 frames seen", n_frames, 2);
    n_checks++;
    if (!((lens[0] == 89342 && lens[1] == 89341) ||
          (lens[0] == 89341 && lens[1] == 89342))) begin
      n_errors++;
      $display("FAIL R3 frame lengths actual=%0d,%0d expected=89342,89341",
               lens[0], lens[1]);
    end
    finished = 1;
    summary();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule